// File: doc/BRIEF.md
# LCD Panel Power Sequencer

This block brings a panel timing controller up and down in a safe order. It writes a fixed series of values into the controller's eight byte-wide registers through a valid/ready write port. The series interleaves the supply-enable bits of two power registers with a panel control register. Fixed millisecond dwells sit between some steps, and the common electrode voltage is set partway through by handing a base pattern and a value to an external two-wire DAC programmer.

A power-on request carries the display mode (VGA or QVGA). It may also carry a stored phase trim and a stored common-voltage level, each qualified by a valid bit. The block remembers whether the panel is already up. A repeat power-on on a live panel only retunes the phase and resolution registers, while a power-off request always runs the full shutdown series and marks the panel down. Dwell lengths are derived from the clock frequency in kHz, so the same RTL serves any clock.

Top module: `lcd_pwr_seq`

## Requirements
- R1: After reset, busy_o and inited_o are low, and neither reg_vld_o nor dac_req_o is asserted.
- R2: A power-on on an uninitialised panel writes (address:data, hex) 6:1F, 3:03, 4:00, 4:04, [3 ms], 3:07, 6:09, [DAC], 3:17, 4:06, [2 ms], 6:01, 3:1F, 4:07, 6:00, phase, 7:00, [1 ms], resolution, in exactly that order.
- R3: A dwell of N ms leaves both ports quiet for exactly N*CLK_KHZ+1 clock cycles between the end of the previous step and the start of the next.
- R4: The phase value written to address 1 is 0x13 in QVGA mode. In VGA mode it is {adj,1} (adj in bits 4:1, bit 0 set) when the stored trim is valid, and 0x01 otherwise.
- R5: During power-up, the DAC step presents base 0x04 and value vcom_i when its valid bit is set, else 125 (0x7D).
- R6: The resolution write goes to address 0 with data 0x00 for VGA and 0x01 for QVGA. Bits 7:1 are always zero.
- R7: A power-on on an initialised panel writes only the phase register and then the resolution register.
- R8: A power-off writes nothing for 34 ms, then 4:06, 6:08, 3:14, [DAC base 0x14 value 0x00], 4:04, 3:04, 6:1E, 3:00, 4:00, and clears inited_o.
- R9: Requests that arrive while busy_o is high are ignored. Mode, trim and voltage are captured on the accepting cycle. If power-on and power-off arrive together, power-off wins.
- R10: reg_vld_o holds with stable address and data until reg_rdy_i. dac_req_o holds with stable base and value until dac_done_i. The two are never high together.
- R11: busy_o rises on the cycle after an accepted request and falls after the final step. inited_o changes only when busy_o falls: it is set after power-up or retune and cleared after power-down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pwr_on_i | input | 1 | Power-on / retune request |
| pwr_off_i | input | 1 | Power-off request |
| qvga_i | input | 1 | Mode for power-on: 1 = QVGA, 0 = VGA |
| phase_adj_i | input | 4 | Stored phase trim |
| phase_adj_vld_i | input | 1 | Phase trim is valid |
| vcom_i | input | 8 | Stored common-voltage level |
| vcom_vld_i | input | 1 | Common-voltage level is valid |
| reg_vld_o | output | 1 | Register write valid |
| reg_rdy_i | input | 1 | Register write accepted |
| reg_addr_o | output | 3 | Register address |
| reg_data_o | output | 8 | Register data |
| dac_req_o | output | 1 | Request to program the common-voltage DAC |
| dac_done_i | input | 1 | DAC programming complete |
| dac_base_o | output | 8 | Power0 base pattern held during DAC transfer |
| dac_val_o | output | 8 | Common-voltage value to program |
| busy_o | output | 1 | A sequence is running |
| inited_o | output | 1 | Panel is powered and initialised |

## Verification
The assertions assume that requests, reg_rdy_i and dac_done_i are synchronous to clk_i. They also assume that the responders may hold a handshake low indefinitely without the block dropping its request. The check that busy_o only rises after a request assumes no request input glitches between edges. The stimulus therefore changes every input a fixed delay after the rising edge. It stalls the write port on a repeating pattern and answers the DAC only after several cycles, so that holding behaviour is exercised.

// File: rtl/lcd_pwr_seq_pkg.sv
package lcd_pwr_seq_pkg;

  localparam int DW = 8;
  localparam int AW = 3;

  localparam logic [AW-1:0] ADDR_RES   = 3'd0;
  localparam logic [AW-1:0] ADDR_PHASE = 3'd1;
  localparam logic [AW-1:0] ADDR_PWR0  = 3'd3;
  localparam logic [AW-1:0] ADDR_PWR1  = 3'd4;
  localparam logic [AW-1:0] ADDR_CTRL  = 3'd6;
  localparam logic [AW-1:0] ADDR_POL   = 3'd7;

  localparam logic [DW-1:0] PHASE_QVGA = 8'h13;
  localparam logic [DW-1:0] VCOM_DFLT  = 8'd125;

  typedef enum logic [2:0] {
    OP_WR, OP_WAIT, OP_DAC, OP_PHASE, OP_RES, OP_END
  } op_e;

  typedef enum logic [1:0] {
    SEQ_UP, SEQ_RETUNE, SEQ_DOWN
  } seq_e;

  typedef struct packed {
    op_e           op;
    logic [AW-1:0] addr;
    logic [DW-1:0] arg;
  } step_t;

  function automatic step_t mk(op_e op, logic [AW-1:0] addr, logic [DW-1:0] arg);
    step_t s;
    s.op   = op;
    s.addr = addr;
    s.arg  = arg;
    return s;
  endfunction

endpackage

// File: rtl/lcd_seq_rom.sv
module lcd_seq_rom
  import lcd_pwr_seq_pkg::*;
#(
  parameter int IDX_W = 5
) (
  input  seq_e             seq_i,
  input  logic [IDX_W-1:0] idx_i,
  output step_t            step_o
);

  always_comb begin
    step_o = mk(OP_END, '0, '0);
    unique case (seq_i)
      SEQ_UP: begin
        case (int'(idx_i))
          0:  step_o = mk(OP_WR,    ADDR_CTRL,  8'h1F);
          1:  step_o = mk(OP_WR,    ADDR_PWR0,  8'h03);
          2:  step_o = mk(OP_WR,    ADDR_PWR1,  8'h00);
          3:  step_o = mk(OP_WR,    ADDR_PWR1,  8'h04);
          4:  step_o = mk(OP_WAIT,  '0,         8'd3);
          5:  step_o = mk(OP_WR,    ADDR_PWR0,  8'h07);
          6:  step_o = mk(OP_WR,    ADDR_CTRL,  8'h09);
          7:  step_o = mk(OP_DAC,   '0,         8'h04);
          8:  step_o = mk(OP_WR,    ADDR_PWR0,  8'h17);
          9:  step_o = mk(OP_WR,    ADDR_PWR1,  8'h06);
          10: step_o = mk(OP_WAIT,  '0,         8'd2);
          11: step_o = mk(OP_WR,    ADDR_CTRL,  8'h01);
          12: step_o = mk(OP_WR,    ADDR_PWR0,  8'h1F);
          13: step_o = mk(OP_WR,    ADDR_PWR1,  8'h07);
          14: step_o = mk(OP_WR,    ADDR_CTRL,  8'h00);
          15: step_o = mk(OP_PHASE, ADDR_PHASE, 8'h00);
          16: step_o = mk(OP_WR,    ADDR_POL,   8'h00);
          17: step_o = mk(OP_WAIT,  '0,         8'd1);
          18: step_o = mk(OP_RES,   ADDR_RES,   8'h00);
          default: step_o = mk(OP_END, '0, '0);
        endcase
      end
      SEQ_RETUNE: begin
        case (int'(idx_i))
          0: step_o = mk(OP_PHASE, ADDR_PHASE, 8'h00);
          1: step_o = mk(OP_RES,   ADDR_RES,   8'h00);
          default: step_o = mk(OP_END, '0, '0);
        endcase
      end
      SEQ_DOWN: begin
        case (int'(idx_i))
          0:  step_o = mk(OP_WAIT, '0,        8'd34); // two frames at 60 Hz
          1:  step_o = mk(OP_WR,   ADDR_PWR1, 8'h06);
          2:  step_o = mk(OP_WR,   ADDR_CTRL, 8'h08);
          3:  step_o = mk(OP_WR,   ADDR_PWR0, 8'h14);
          4:  step_o = mk(OP_DAC,  '0,        8'h14);
          5:  step_o = mk(OP_WR,   ADDR_PWR1, 8'h04);
          6:  step_o = mk(OP_WR,   ADDR_PWR0, 8'h04);
          7:  step_o = mk(OP_WR,   ADDR_CTRL, 8'h1E);
          8:  step_o = mk(OP_WR,   ADDR_PWR0, 8'h00);
          9:  step_o = mk(OP_WR,   ADDR_PWR1, 8'h00);
          default: step_o = mk(OP_END, '0, '0);
        endcase
      end
      default: step_o = mk(OP_END, '0, '0);
    endcase
  end

endmodule

// File: rtl/lcd_ms_timer.sv
module lcd_ms_timer #(
  parameter int CLK_KHZ = 100_000,
  parameter int MS_W    = 6
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic [MS_W-1:0] ms_i,
  output logic            done_o
);

  localparam int PRE_W = (CLK_KHZ > 1) ? $clog2(CLK_KHZ) : 1;
  localparam logic [PRE_W-1:0] PRE_MAX = PRE_W'(CLK_KHZ - 1);

  logic             run_q;
  logic [PRE_W-1:0] pre_q;
  logic [MS_W-1:0]  ms_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      pre_q <= '0;
      ms_q  <= '0;
    end else if (start_i) begin
      run_q <= 1'b1;
      pre_q <= PRE_MAX;
      ms_q  <= ms_i;
    end else if (run_q) begin
      if (pre_q == '0) begin
        pre_q <= PRE_MAX;
        ms_q  <= ms_q - 1'b1;
        if (ms_q == MS_W'(1)) run_q <= 1'b0;
      end else begin
        pre_q <= pre_q - 1'b1;
      end
    end
  end

  // high on the last cycle of the final millisecond
  assign done_o = run_q && (pre_q == '0) && (ms_q == MS_W'(1));

endmodule

// File: rtl/lcd_seq_ctrl.sv
module lcd_seq_ctrl
  import lcd_pwr_seq_pkg::*;
#(
  parameter int IDX_W = 5,
  parameter int MS_W  = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pwr_on_i,
  input  logic             pwr_off_i,
  input  logic             qvga_i,
  input  logic [3:0]       phase_adj_i,
  input  logic             phase_adj_vld_i,
  input  logic [DW-1:0]    vcom_i,
  input  logic             vcom_vld_i,
  output seq_e             seq_o,
  output logic [IDX_W-1:0] idx_o,
  input  step_t            step_i,
  output logic             reg_vld_o,
  input  logic             reg_rdy_i,
  output logic [AW-1:0]    reg_addr_o,
  output logic [DW-1:0]    reg_data_o,
  output logic             dac_req_o,
  input  logic             dac_done_i,
  output logic [DW-1:0]    dac_base_o,
  output logic [DW-1:0]    dac_val_o,
  output logic             tmr_start_o,
  output logic [MS_W-1:0]  tmr_ms_o,
  input  logic             tmr_done_i,
  output logic             busy_o,
  output logic             inited_o
);

  logic             busy_q, inited_q, armed_q, qvga_q;
  seq_e             seq_q;
  logic [IDX_W-1:0] idx_q;
  logic [DW-1:0]    phase_q, vcom_q;
  logic             advance, finish;

  always_comb begin
    advance     = 1'b0;
    finish      = 1'b0;
    reg_vld_o   = 1'b0;
    reg_addr_o  = '0;
    reg_data_o  = '0;
    dac_req_o   = 1'b0;
    tmr_start_o = 1'b0;
    if (busy_q) begin
      unique case (step_i.op)
        OP_WR: begin
          reg_vld_o  = 1'b1;
          reg_addr_o = step_i.addr;
          reg_data_o = step_i.arg;
          advance    = reg_rdy_i;
        end
        OP_PHASE: begin
          reg_vld_o  = 1'b1;
          reg_addr_o = ADDR_PHASE;
          reg_data_o = phase_q;
          advance    = reg_rdy_i;
        end
        OP_RES: begin
          reg_vld_o  = 1'b1;
          reg_addr_o = ADDR_RES;
          reg_data_o = {7'b0, qvga_q};
          advance    = reg_rdy_i;
        end
        OP_DAC: begin
          dac_req_o = 1'b1;
          advance   = dac_done_i;
        end
        OP_WAIT: begin
          tmr_start_o = !armed_q;
          advance     = armed_q && tmr_done_i;
        end
        default: finish = 1'b1;
      endcase
    end
  end

  assign tmr_ms_o   = step_i.arg[MS_W-1:0];
  assign dac_base_o = dac_req_o ? step_i.arg : '0;
  assign dac_val_o  = !dac_req_o ? '0 : (seq_q == SEQ_DOWN) ? '0 : vcom_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q   <= 1'b0;
      inited_q <= 1'b0;
      armed_q  <= 1'b0;
      qvga_q   <= 1'b0;
      seq_q    <= SEQ_UP;
      idx_q    <= '0;
      phase_q  <= '0;
      vcom_q   <= '0;
    end else if (!busy_q) begin
      idx_q   <= '0;
      armed_q <= 1'b0;
      if (pwr_off_i) begin
        busy_q <= 1'b1;
        seq_q  <= SEQ_DOWN;
      end else if (pwr_on_i) begin
        busy_q  <= 1'b1;
        seq_q   <= inited_q ? SEQ_RETUNE : SEQ_UP;
        qvga_q  <= qvga_i;
        phase_q <= qvga_i ? PHASE_QVGA :
                   phase_adj_vld_i ? {3'b0, phase_adj_i, 1'b1} : 8'h01;
        vcom_q  <= vcom_vld_i ? vcom_i : VCOM_DFLT;
      end
    end else if (finish) begin
      busy_q   <= 1'b0;
      inited_q <= (seq_q != SEQ_DOWN);
    end else if (advance) begin
      idx_q   <= idx_q + 1'b1;
      armed_q <= 1'b0;
    end else if (tmr_start_o) begin
      armed_q <= 1'b1;
    end
  end

  assign seq_o    = seq_q;
  assign idx_o    = idx_q;
  assign busy_o   = busy_q;
  assign inited_o = inited_q;

endmodule

// File: rtl/lcd_pwr_seq.sv
module lcd_pwr_seq
  import lcd_pwr_seq_pkg::*;
#(
  parameter int CLK_KHZ = 100_000,
  parameter int MS_W    = 6,
  parameter int IDX_W   = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          pwr_on_i,
  input  logic          pwr_off_i,
  input  logic          qvga_i,
  input  logic [3:0]    phase_adj_i,
  input  logic          phase_adj_vld_i,
  input  logic [7:0]    vcom_i,
  input  logic          vcom_vld_i,
  output logic          reg_vld_o,
  input  logic          reg_rdy_i,
  output logic [2:0]    reg_addr_o,
  output logic [7:0]    reg_data_o,
  output logic          dac_req_o,
  input  logic          dac_done_i,
  output logic [7:0]    dac_base_o,
  output logic [7:0]    dac_val_o,
  output logic          busy_o,
  output logic          inited_o
);

  seq_e             seq;
  logic [IDX_W-1:0] idx;
  step_t            step;
  logic             tmr_start, tmr_done;
  logic [MS_W-1:0]  tmr_ms;

  lcd_seq_rom #(.IDX_W(IDX_W)) u_rom (
    .seq_i  (seq),
    .idx_i  (idx),
    .step_o (step)
  );

  lcd_ms_timer #(.CLK_KHZ(CLK_KHZ), .MS_W(MS_W)) u_tmr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (tmr_start),
    .ms_i    (tmr_ms),
    .done_o  (tmr_done)
  );

  lcd_seq_ctrl #(.IDX_W(IDX_W), .MS_W(MS_W)) u_ctrl (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .pwr_on_i        (pwr_on_i),
    .pwr_off_i       (pwr_off_i),
    .qvga_i          (qvga_i),
    .phase_adj_i     (phase_adj_i),
    .phase_adj_vld_i (phase_adj_vld_i),
    .vcom_i          (vcom_i),
    .vcom_vld_i      (vcom_vld_i),
    .seq_o           (seq),
    .idx_o           (idx),
    .step_i          (step),
    .reg_vld_o       (reg_vld_o),
    .reg_rdy_i       (reg_rdy_i),
    .reg_addr_o      (reg_addr_o),
    .reg_data_o      (reg_data_o),
    .dac_req_o       (dac_req_o),
    .dac_done_i      (dac_done_i),
    .dac_base_o      (dac_base_o),
    .dac_val_o       (dac_val_o),
    .tmr_start_o     (tmr_start),
    .tmr_ms_o        (tmr_ms),
    .tmr_done_i      (tmr_done),
    .busy_o          (busy_o),
    .inited_o        (inited_o)
  );

endmodule

// File: rtl/lcd_pwr_seq_chk.sv
module lcd_pwr_seq_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       pwr_on_i,
  input logic       pwr_off_i,
  input logic       reg_vld_o,
  input logic       reg_rdy_i,
  input logic [2:0] reg_addr_o,
  input logic [7:0] reg_data_o,
  input logic       dac_req_o,
  input logic       dac_done_i,
  input logic [7:0] dac_base_o,
  input logic [7:0] dac_val_o,
  input logic       busy_o,
  input logic       inited_o
);

  a_r10_reg_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_vld_o && !reg_rdy_i |=> reg_vld_o && $stable(reg_addr_o) && $stable(reg_data_o));

  a_r10_dac_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dac_req_o && !dac_done_i |=> dac_req_o && $stable(dac_base_o) && $stable(dac_val_o));

  a_r10_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(reg_vld_o && dac_req_o));

  a_r11_act_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_vld_o || dac_req_o) |-> busy_o);

  a_r11_busy_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(pwr_on_i || pwr_off_i));

  a_r11_init_at_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(inited_o) |-> $fell(busy_o));

  a_r6_res_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_vld_o && (reg_addr_o == 3'd0) |-> (reg_data_o[7:1] == 7'd0));

endmodule

bind lcd_pwr_seq lcd_pwr_seq_chk u_chk (.*);

// File: tb/lcd_pwr_seq_bench.sv
module lcd_pwr_seq_bench;

  localparam int K = 4;

  logic clk = 0, rst_n = 0;
  logic pwr_on = 0, pwr_off = 0, qvga = 0, adj_vld = 0, vcom_vld = 0;
  logic [3:0] adj = 0;
  logic [7:0] vcom = 0;
  logic reg_rdy = 0, dac_done = 0;
  logic reg_vld, dac_req, busy, inited;
  logic [2:0] reg_addr;
  logic [7:0] reg_data, dac_base, dac_val;

  always #5 clk = ~clk;

  lcd_pwr_seq #(.CLK_KHZ(K)) u_lcd_pwr_seq (
    .clk_i(clk), .rst_ni(rst_n), .pwr_on_i(pwr_on), .pwr_off_i(pwr_off),
    .qvga_i(qvga), .phase_adj_i(adj), .phase_adj_vld_i(adj_vld),
    .vcom_i(vcom), .vcom_vld_i(vcom_vld), .reg_vld_o(reg_vld),
    .reg_rdy_i(reg_rdy), .reg_addr_o(reg_addr), .reg_data_o(reg_data),
    .dac_req_o(dac_req), .dac_done_i(dac_done), .dac_base_o(dac_base),
    .dac_val_o(dac_val), .busy_o(busy), .inited_o(inited)
  );

  // kind: 0 write, 1 wait, 2 dac, 3 end
  typedef struct {int kind; int a; int d; int r;} item_t;
  item_t q[$];
  int n_chk = 0, n_fail = 0, cyc = 0, end_cyc = -1, wcnt = 0;
  bit m_init = 0, stall = 0, finished = 0;
  logic [2:0] st_addr;
  logic [7:0] st_data;

  task automatic chk(bit ok, int r, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL R%0d actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  function automatic void pw(int a, int d, int r); item_t it = '{0, a, d, r}; q.push_back(it); endfunction
  function automatic void wt(int n);               item_t it = '{1, 0, n, 3}; q.push_back(it); endfunction
  function automatic void dc(int b, int v, int r); item_t it = '{2, b, v, r}; q.push_back(it); endfunction
  function automatic void en(int s);               item_t it = '{3, s, 0, 11}; q.push_back(it); endfunction

  function automatic void push_up(int qv, int ph, int vc);  // R2 R4 R5 R6
    pw(6,'h1F,2); pw(3,'h03,2); pw(4,'h00,2); pw(4,'h04,2); wt(3);
    pw(3,'h07,2); pw(6,'h09,2); dc('h04,vc,5); pw(3,'h17,2); pw(4,'h06,2); wt(2);
    pw(6,'h01,2); pw(3,'h1F,2); pw(4,'h07,2); pw(6,'h00,2); pw(1,ph,4);
    pw(7,'h00,2); wt(1); pw(0,qv,6); en(1);
  endfunction

  function automatic void push_re(int qv, int ph);  // R7
    pw(1,ph,7); pw(0,qv,7); en(1);
  endfunction

  function automatic void push_dn();  // R8
    wt(34); pw(4,'h06,8); pw(6,'h08,8); pw(3,'h14,8); dc('h14,0,8);
    pw(4,'h04,8); pw(3,'h04,8); pw(6,'h1E,8); pw(3,'h00,8); pw(4,'h00,8); en(0);
  endfunction

  // responders
  int rc = 0, dn = 0;
  always @(posedge clk) begin
    #1;
    rc = rc + 1;
    reg_rdy = (rc % 3) != 1;
    if (dac_req && !dac_done) begin
      dn = dn + 1;
      if (dn >= 3) dac_done = 1;
    end else begin
      dac_done = 0;
      dn = 0;
    end
  end

  // reference comparison every cycle
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      cyc++;
      if (stall) begin  // R10
        chk(reg_vld && reg_addr == st_addr && reg_data == st_data, 10,
            {reg_vld, reg_addr, reg_data}, {1'b1, st_addr, st_data});
      end
      stall = reg_vld && !reg_rdy;
      st_addr = reg_addr;
      st_data = reg_data;
      if (q.size() > 0 && q[0].kind == 1) begin
        if (reg_vld || dac_req) begin  // R3
          chk(wcnt == q[0].d * K + 1, 3, wcnt, q[0].d * K + 1);
          void'(q.pop_front());
          wcnt = 0;
        end else begin
          wcnt++;
          if (!busy) chk(0, 11, busy, 1);
        end
      end
      if (q.size() == 0) begin  // R11
        if (busy || reg_vld || dac_req)
          chk(0, 11, {busy, reg_vld, dac_req}, 0);
      end else if (q[0].kind == 0) begin
        chk(reg_vld && !dac_req && busy, q[0].r, {reg_vld, dac_req, busy}, 3'b101);
        if (reg_vld) begin
          chk(reg_addr == q[0].a[2:0] && reg_data == q[0].d[7:0], q[0].r,
              {reg_addr, reg_data}, {q[0].a[2:0], q[0].d[7:0]});
          if (reg_rdy) void'(q.pop_front());
        end
      end else if (q[0].kind == 2) begin
        chk(dac_req && !reg_vld, q[0].r, {dac_req, reg_vld}, 2'b10);
        if (dac_req) begin
          chk(dac_base == q[0].a[7:0] && dac_val == q[0].d[7:0], q[0].r,
              {dac_base, dac_val}, {q[0].a[7:0], q[0].d[7:0]});
          if (dac_done) void'(q.pop_front());
        end
      end else if (q[0].kind == 3) begin
        chk(busy && !reg_vld && !dac_req, 11, {busy, reg_vld, dac_req}, 3'b100);
        m_init = (q[0].a != 0);
        end_cyc = cyc;
        void'(q.pop_front());
      end
    end
  end

  task automatic req(bit on, bit off, bit qv, bit av, int a, bit vv, int v);
    int ph, vc;
    @(posedge clk);
    #1;
    pwr_on = on; pwr_off = off; qvga = qv; adj_vld = av; adj = a[3:0];
    vcom_vld = vv; vcom = v[7:0];
    @(posedge clk);
    ph = qv ? 'h13 : (av ? ((a & 15) * 2 + 1) : 1);
    vc = vv ? (v & 255) : 125;
    if (q.size() == 0 && cyc != end_cyc) begin  // R9 acceptance model
      if (off) push_dn();
      else if (on) begin
        if (m_init) push_re(qv, ph);
        else push_up(qv, ph, vc);
      end
    end
    #1;
    pwr_on = 0; pwr_off = 0;
    qvga = ~qv; adj = ~a[3:0]; adj_vld = ~av; vcom = ~v[7:0]; vcom_vld = ~vv;
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (q.size() != 0 || busy);
    repeat (2) @(negedge clk);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  always @(negedge clk) begin
    if (cyc > 100000 && !finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    // R1
    chk(!busy && !inited && !reg_vld && !dac_req, 1, {busy, inited, reg_vld, dac_req}, 0);

    // full power-up, VGA, valid trim 0xB, valid vcom 0x5A; mid-run requests ignored (R9)
    req(1, 0, 0, 1, 'hB, 1, 'h5A);
    repeat (8) @(posedge clk);
    req(0, 1, 0, 0, 0, 0, 0);
    req(1, 0, 1, 0, 0, 0, 0);
    wait_idle();
    chk(inited == 1, 9, inited, 1);   // R9: off during run ignored
    chk(inited == 1, 11, inited, 1);

    req(1, 0, 1, 1, 'h3, 1, 'h10);   // retune QVGA (R7, R4)
    wait_idle();
    req(1, 0, 0, 0, 'h6, 0, 0);      // retune VGA, no trim -> 0x01
    wait_idle();
    chk(inited == 1, 7, inited, 1);

    req(1, 1, 1, 1, 'h2, 1, 'h20);   // both at once: off wins (R9)
    wait_idle();
    chk(inited == 0, 8, inited, 0);

    req(1, 0, 1, 0, 0, 0, 0);        // QVGA, default vcom 125 (R5)
    wait_idle();
    chk(inited == 1, 11, inited, 1);
    req(0, 1, 0, 0, 0, 0, 0);
    wait_idle();
    chk(inited == 0, 8, inited, 0);

    req(1, 0, 0, 1, 'hF, 1, 'hC3);   // VGA trim 0xF -> 0x1F
    wait_idle();
    chk(inited == 1, 2, inited, 1);
    req(0, 1, 0, 0, 0, 0, 0);
    wait_idle();
    chk(!busy && !inited, 8, {busy, inited}, 0);
    summary();
  end

endmodule